// File: doc/BRIEF.md
# Power-Aware Interrupt Priority Selector

This block decides which pending interrupt a processor core takes next. It considers the core's execution-mode flags (external enable, hypervisor state, problem state and a resume-as-reset flag), the partition-level enables for the hypervisor decrementer, hypervisor virtualization and external sources, and whether the core is halted in a power-saving state. A ranked chain picks one source, and the result appears as a one-hot code with a valid flag. Vector fetch, state save and program-counter update belong to the surrounding core.

While the core is halted, an exit-criterion bit chooses between two ways to wake it. When the bit is set, the normal chain is bypassed. A separate wake-enable mask then chooses among the pending sources. When the bit is clear, every system-caused source may wake the core. If the architectural external-enable flag is clear in that case, the block reports a wake without delivery: the core resumes at the next instruction and takes no interrupt.

All outputs are registered once and cleared by a synchronous active-high reset.

Top module: `power_irq_select`

## Requirements
- R1: Source encoding on `pending_i`, `wake_en_i` and `irq_code_o`:
  - bit 0 is machine check;
  - bit 1 is hypervisor decrementer;
  - bit 2 is hypervisor virtualization;
  - bit 3 is external;
  - bit 4 is decrementer.
  
  Outside the halted-with-exit-criterion case, a pending machine check is always chosen, whatever the enables and mode flags are.
- R2: The effective external-enable term is the OR of `msr_ee_i` and `resume_rst_i`.
- R3: The hypervisor decrementer is eligible only when `hdec_en_i` is 1 and either the effective enable is 1 or `msr_hv_i` is 0.
- R4: The hypervisor virtualization source is gated exactly as in R3, but with `hvirt_en_i` in place of `hdec_en_i`.
- R5: The external source is eligible when either of these holds:
  - the effective enable is 1, and not all of `ext_hv_block_i`=1, `msr_hv_i`=1 and `msr_pr_i`=0 hold;
  - `hv_present_i`=1, `msr_hv_i`=0 and `ext_route_i`=0.
- R6: The decrementer is eligible only when the effective enable is 1. Among eligible sources, the ranking is machine check, then hypervisor decrementer, then hypervisor virtualization, then external, then decrementer.
- R7: When `halted_i`=1 and `exit_crit_i`=1, the chosen source is the lowest-index bit of `pending_i & wake_en_i`, and all gating enables and mode flags are ignored. If that AND is zero, nothing is chosen.
- R8: When `halted_i`=1 and `exit_crit_i`=0, the effective enable is forced to 1.
- R9: When `halted_i`=1, `exit_crit_i`=0 and `msr_ee_i`=0, and some source is chosen, `wake_only_o` is 1 and `irq_valid_o` is 0. `irq_code_o` still shows the chosen source. `resume_rst_i` does not prevent this.
- R10: `irq_code_o` is one-hot or zero. When nothing is chosen, `irq_valid_o`, `wake_only_o` and `irq_code_o` are all 0. `irq_valid_o` and `wake_only_o` are never both 1.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge. A synchronous reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pending_i | input | 5 | Pending interrupt sources |
| wake_en_i | input | 5 | Per-source wake enable for the exit-criterion path |
| msr_ee_i | input | 1 | External-enable mode flag |
| msr_hv_i | input | 1 | Hypervisor mode flag |
| msr_pr_i | input | 1 | Problem-state flag |
| resume_rst_i | input | 1 | Resume-as-reset flag |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| hvirt_en_i | input | 1 | Hypervisor virtualization enable |
| ext_hv_block_i | input | 1 | Blocks external delivery to the hypervisor |
| ext_route_i | input | 1 | External routing bit; 0 lets a guest-side external through |
| hv_present_i | input | 1 | Hypervisor support exists |
| halted_i | input | 1 | Core halted in power-saving state |
| exit_crit_i | input | 1 | Exit criterion: 1 selects the wake-mask path while halted |
| irq_code_o | output | 5 | One-hot chosen source |
| irq_valid_o | output | 1 | Chosen source is to be delivered |
| wake_only_o | output | 1 | Wake the core without delivering |

## Verification
The assertions compare registered outputs with inputs taken one cycle earlier. They therefore assume that every input is stable across each rising edge and that no cycle straddles reset release. The bench meets this by changing inputs only one time unit after an edge and by holding reset for whole cycles. The assertions place no limit on the combinations of mode flags and enables, so the directed tasks freely include contradictory settings, such as problem state together with hypervisor mode.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

  localparam int unsigned NUM_SRC = 5;

  localparam int unsigned SRC_MCK   = 0;
  localparam int unsigned SRC_HDEC  = 1;
  localparam int unsigned SRC_HVIRT = 2;
  localparam int unsigned SRC_EXT   = 3;
  localparam int unsigned SRC_DEC   = 4;

  typedef struct packed {
    logic ee;
    logic hv;
    logic pr;
    logic resume;
  } mode_t;

  typedef struct packed {
    logic hdec_en;
    logic hvirt_en;
    logic ext_hv_block;
    logic ext_route;
    logic hv_present;
  } ctrl_t;

endpackage

// File: rtl/irqsel_lowest_pick.sv
module irqsel_lowest_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];

endmodule

// File: rtl/irqsel_gate.sv
module irqsel_gate
  import irqsel_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic [N-1:0] pending,
  input  mode_t        mode,
  input  ctrl_t        ctrl,
  input  logic         force_ee,
  output logic [N-1:0] elig
);

  logic ee_eff;
  logic hv_gate;
  logic ext_own;
  logic ext_guest;

  // Effective external-enable, forced while halted without exit criterion.
  assign ee_eff    = mode.ee | mode.resume | force_ee;
  assign hv_gate   = ee_eff | ~mode.hv;
  assign ext_own   = ee_eff & ~(ctrl.ext_hv_block & mode.hv & ~mode.pr);
  assign ext_guest = ctrl.hv_present & ~mode.hv & ~ctrl.ext_route;

  always_comb begin
    elig            = '0;
    elig[SRC_MCK]   = pending[SRC_MCK];
    elig[SRC_HDEC]  = pending[SRC_HDEC]  & ctrl.hdec_en  & hv_gate;
    elig[SRC_HVIRT] = pending[SRC_HVIRT] & ctrl.hvirt_en & hv_gate;
    elig[SRC_EXT]   = pending[SRC_EXT]   & (ext_own | ext_guest);
    elig[SRC_DEC]   = pending[SRC_DEC]   & ee_eff;
  end

endmodule

// File: rtl/power_irq_select.sv
module power_irq_select
  import irqsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pending_i,
  input  logic [NUM_SRC-1:0] wake_en_i,
  input  logic               msr_ee_i,
  input  logic               msr_hv_i,
  input  logic               msr_pr_i,
  input  logic               resume_rst_i,
  input  logic               hdec_en_i,
  input  logic               hvirt_en_i,
  input  logic               ext_hv_block_i,
  input  logic               ext_route_i,
  input  logic               hv_present_i,
  input  logic               halted_i,
  input  logic               exit_crit_i,
  output logic [NUM_SRC-1:0] irq_code_o,
  output logic               irq_valid_o,
  output logic               wake_only_o
);

  localparam int unsigned N = NUM_SRC;

  mode_t        mode;
  ctrl_t        ctrl;
  logic         use_wake;
  logic         halt_any;
  logic [N-1:0] chain_elig;
  logic [N-1:0] chain_grant;
  logic         chain_any;
  logic [N-1:0] wake_req;
  logic [N-1:0] wake_grant;
  logic         wake_any;
  logic [N-1:0] nxt_code;
  logic         nxt_valid;
  logic         nxt_wake_only;

  assign mode = '{ee: msr_ee_i, hv: msr_hv_i, pr: msr_pr_i, resume: resume_rst_i};
  assign ctrl = '{hdec_en: hdec_en_i, hvirt_en: hvirt_en_i,
                  ext_hv_block: ext_hv_block_i, ext_route: ext_route_i,
                  hv_present: hv_present_i};

  assign use_wake = halted_i & exit_crit_i;
  assign halt_any = halted_i & ~exit_crit_i;

  irqsel_gate #(.N(N)) u_gate (
    .pending  (pending_i),
    .mode     (mode),
    .ctrl     (ctrl),
    .force_ee (halt_any),
    .elig     (chain_elig)
  );

  irqsel_lowest_pick #(.N(N)) u_chain_pick (
    .req   (chain_elig),
    .grant (chain_grant),
    .any   (chain_any)
  );

  assign wake_req = pending_i & wake_en_i;

  irqsel_lowest_pick #(.N(N)) u_wake_pick (
    .req   (wake_req),
    .grant (wake_grant),
    .any   (wake_any)
  );

  always_comb begin
    if (use_wake) begin
      nxt_code      = wake_grant;
      nxt_valid     = wake_any;
      nxt_wake_only = 1'b0;
    end else begin
      nxt_code      = chain_grant;
      nxt_wake_only = halt_any & ~msr_ee_i & chain_any;
      nxt_valid     = chain_any & ~nxt_wake_only;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_code_o  <= '0;
      irq_valid_o <= 1'b0;
      wake_only_o <= 1'b0;
    end else begin
      irq_code_o  <= nxt_code;
      irq_valid_o <= nxt_valid;
      wake_only_o <= nxt_wake_only;
    end
  end

endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk
  import irqsel_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] pending_i,
  input logic [NUM_SRC-1:0] wake_en_i,
  input logic               msr_ee_i,
  input logic               resume_rst_i,
  input logic               halted_i,
  input logic               exit_crit_i,
  input logic [NUM_SRC-1:0] irq_code_o,
  input logic               irq_valid_o,
  input logic               wake_only_o
);

  // R10
  code_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_code_o));

  // R10
  valid_wake_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_valid_o && wake_only_o));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_valid_o && !wake_only_o) |-> irq_code_o == '0);

  // R1
  mck_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pending_i[SRC_MCK] && !halted_i))
      |-> (irq_valid_o && irq_code_o[SRC_MCK]));

  // R7
  wake_none_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(halted_i && exit_crit_i && ((pending_i & wake_en_i) == '0)))
      |-> (!irq_valid_o && irq_code_o == '0));

  // R9
  wake_only_src_chk: assert property (@(posedge clk) disable iff (rst)
    wake_only_o |-> $past(halted_i && !exit_crit_i && !msr_ee_i));

  // R6
  dec_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!halted_i && !msr_ee_i && !resume_rst_i))
      |-> !irq_code_o[SRC_DEC]);

  // R11
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_code_o == '0 && !irq_valid_o && !wake_only_o));

endmodule

bind power_irq_select irqsel_chk u_irqsel_chk (
  .clk          (clk),
  .rst          (rst),
  .pending_i    (pending_i),
  .wake_en_i    (wake_en_i),
  .msr_ee_i     (msr_ee_i),
  .resume_rst_i (resume_rst_i),
  .halted_i     (halted_i),
  .exit_crit_i  (exit_crit_i),
  .irq_code_o   (irq_code_o),
  .irq_valid_o  (irq_valid_o),
  .wake_only_o  (wake_only_o)
);

// File: tb/test_power_irq_select.sv
module test_power_irq_select;

  localparam logic [4:0] C_NONE  = 5'b00000;
  localparam logic [4:0] C_MCK   = 5'b00001;
  localparam logic [4:0] C_HDEC  = 5'b00010;
  localparam logic [4:0] C_HVIRT = 5'b00100;
  localparam logic [4:0] C_EXT   = 5'b01000;
  localparam logic [4:0] C_DEC   = 5'b10000;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] pending, wake_en;
  logic       ee, hv, pr, resume, hdec_en, hvirt_en, ext_block, ext_route, hv_present;
  logic       halted, exit_crit;
  logic [4:0] code;
  logic       valid, wake_only;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  power_irq_select i_power_irq_select (
    .clk            (clk),
    .rst            (rst),
    .pending_i      (pending),
    .wake_en_i      (wake_en),
    .msr_ee_i       (ee),
    .msr_hv_i       (hv),
    .msr_pr_i       (pr),
    .resume_rst_i   (resume),
    .hdec_en_i      (hdec_en),
    .hvirt_en_i     (hvirt_en),
    .ext_hv_block_i (ext_block),
    .ext_route_i    (ext_route),
    .hv_present_i   (hv_present),
    .halted_i       (halted),
    .exit_crit_i    (exit_crit),
    .irq_code_o     (code),
    .irq_valid_o    (valid),
    .wake_only_o    (wake_only)
  );

  task automatic clear_inputs();
    pending = '0; wake_en = '0;
    ee = 0; hv = 0; pr = 0; resume = 0;
    hdec_en = 0; hvirt_en = 0; ext_block = 0; ext_route = 0; hv_present = 0;
    halted = 0; exit_crit = 0;
  endtask

  task automatic check_now(input logic [4:0] ec, input logic ev, input logic ew,
                           input string tag);
    n_checks++;
    if (code !== ec || valid !== ev || wake_only !== ew) begin
      n_fail++;
      $display("FAIL %s: code=%b valid=%b wake=%b expected code=%b valid=%b wake=%b",
               tag, code, valid, wake_only, ec, ev, ew);
    end
  endtask

  // Inputs were set just after the previous edge; sample after the next edge.
  task automatic step(input logic [4:0] ec, input logic ev, input logic ew,
                      input string tag);
    @(posedge clk); #1;
    check_now(ec, ev, ew, tag);
  endtask

  task automatic t_reset();
    rst = 1; clear_inputs(); pending = 5'b11111; ee = 1;
    step(C_NONE, 0, 0, "R11 reset clears outputs");
    rst = 0;
    step(C_MCK, 1, 0, "R11 first cycle after reset");
  endtask

  task automatic t_mck();
    clear_inputs(); pending = 5'b11111;
    step(C_MCK, 1, 0, "R1 machine check with all enables clear");
    hv = 1; pr = 1; ext_block = 1;
    step(C_MCK, 1, 0, "R1 machine check under other mode flags");
  endtask

  task automatic t_order();
    clear_inputs(); ee = 1; hv = 1; hdec_en = 1; hvirt_en = 1;
    pending = 5'b11110;
    step(C_HDEC, 1, 0, "R6 hdec above hvirt/ext/dec");
    pending = 5'b11100;
    step(C_HVIRT, 1, 0, "R6 hvirt above ext/dec");
    pending = 5'b11000;
    step(C_EXT, 1, 0, "R6 ext above dec");
    pending = 5'b10000;
    step(C_DEC, 1, 0, "R6 dec alone");
  endtask

  task automatic t_hdec();
    clear_inputs(); pending = C_HDEC; ee = 1;
    step(C_NONE, 0, 0, "R3 hdec blocked by its enable");
    hdec_en = 1; ee = 0; hv = 1;
    step(C_NONE, 0, 0, "R3 hdec blocked in hv mode with EE off");
    hv = 0;
    step(C_HDEC, 1, 0, "R3 hdec outside hv mode");
    hv = 1; resume = 1;
    step(C_HDEC, 1, 0, "R2 resume flag acts as enable for hdec");
  endtask

  task automatic t_hvirt();
    clear_inputs(); pending = C_HVIRT; hvirt_en = 1; hdec_en = 1; hv = 1;
    step(C_NONE, 0, 0, "R4 hvirt blocked in hv mode with EE off");
    hv = 0;
    step(C_HVIRT, 1, 0, "R4 hvirt outside hv mode");
    hvirt_en = 0;
    step(C_NONE, 0, 0, "R4 hvirt blocked by its own enable");
  endtask

  task automatic t_ext();
    clear_inputs(); pending = C_EXT; ee = 1; ext_block = 1; hv = 1; hv_present = 1;
    step(C_NONE, 0, 0, "R5 hv block stops ext");
    pr = 1;
    step(C_EXT, 1, 0, "R5 problem state lifts block");
    clear_inputs(); pending = C_EXT; hv_present = 1;
    step(C_EXT, 1, 0, "R5 guest routing with EE off");
    ext_route = 1;
    step(C_NONE, 0, 0, "R5 routing bit set stops guest path");
    ext_route = 0; hv_present = 0;
    step(C_NONE, 0, 0, "R5 no hv support stops guest path");
  endtask

  task automatic t_dec();
    clear_inputs(); pending = C_DEC;
    step(C_NONE, 0, 0, "R6 dec blocked with EE off");
    resume = 1;
    step(C_DEC, 1, 0, "R2 resume flag enables dec");
  endtask

  task automatic t_wake_mask();
    clear_inputs(); halted = 1; exit_crit = 1;
    pending = 5'b00011; wake_en = 5'b00010;
    step(C_HDEC, 1, 0, "R7 wake mask picks masked source, enables ignored");
    wake_en = 5'b00000;
    step(C_NONE, 0, 0, "R7 empty wake mask selects nothing");
    pending = 5'b11000; wake_en = 5'b11111;
    step(C_EXT, 1, 0, "R7 lowest index of masked set");
  endtask

  task automatic t_halt_plain();
    clear_inputs(); halted = 1; pending = C_DEC;
    step(C_DEC, 0, 1, "R9 wake without delivery");
    ee = 1;
    step(C_DEC, 1, 0, "R8 forced enable, delivered with EE on");
    ee = 0; resume = 1; hv = 1; hdec_en = 1; pending = C_HDEC;
    step(C_HDEC, 0, 1, "R9 resume flag does not suppress wake-only");
    resume = 0; pending = C_NONE;
    step(C_NONE, 0, 0, "R10 nothing pending while halted");
  endtask

  task automatic t_latency();
    clear_inputs(); ee = 1; pending = C_DEC;
    step(C_DEC, 1, 0, "R11 setup");
    pending = C_NONE; #1;
    check_now(C_DEC, 1, 0, "R11 output held before edge");
    step(C_NONE, 0, 0, "R10 idle after edge");
    pending = 5'b11111; rst = 1;
    step(C_NONE, 0, 0, "R11 mid-run reset clears");
    rst = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    clear_inputs(); rst = 1;
    @(posedge clk); #1;
    t_reset();
    t_mck();
    t_order();
    t_hdec();
    t_hvirt();
    t_ext();
    t_dec();
    t_wake_mask();
    t_halt_plain();
    t_latency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule